// File: doc/BRIEF.md
# Delay Code Loader with Parallel and Serial Programming

This block holds the code that selects the tap of a programmable delay element. A mode input chooses how the code arrives. In parallel mode a bus of code pins feeds the active code. An enable input either passes that bus through or, when low, freezes the last value taken. In serial mode a separate input register takes one bit per rising edge of a serial clock while enable is high, with the most significant bit first. The active code stays as it was until enable falls, and only then does the register contents become active.

While bits are shifted in, the earlier register contents leave on a serial output, most significant bit first. This lets several units be chained, with 8 bits per unit. It also lets the code be read back by looping the output into the input. Such a read leaves the register as it was, so the active code does not change and no settling time is flagged.

Whenever the active code takes a new value, a flag stays high for a set number of system clocks. The delay element needs that time to settle. The serial clock and enable are sampled in the system clock domain and edge-detected, so they act as synchronous strobes.

Top module: `dly_code_prog`

## Requirements
- R1: After reset the active code is 0x00, the input register is 0x00, the settle flag is low, and the serial output is low in serial mode.
- R2: In parallel mode (`mode_par`=1) with enable high, the active code equals the parallel bus value sampled at the previous clock edge.
- R3: In parallel mode with enable low, the active code holds its value whatever the parallel bus does.
- R4: In parallel mode the serial output mirrors bit 0 of the parallel bus, and serial clock edges leave the input register unchanged.
- R5: In serial mode (`mode_par`=0) a rising serial clock edge seen while enable is high shifts the data input into bit 0 of the input register, moving each bit one place toward bit 7. The active code does not change while enable is high.
- R6: In serial mode, serial clock edges seen while enable is low leave the input register unchanged.
- R7: In serial mode a falling edge of enable copies the input register into the active code on the next clock.
- R8: In serial mode the serial output shows bit 7 of the input register. It is valid as soon as enable rises, before any serial clock edge, so old contents leave most significant bit first.
- R9: Eight shifts with the serial output looped to the data input return the stored code on the serial output and restore the register. The following enable fall leaves the code unchanged and the settle flag low.
- R10: Each change of the active code raises the settle flag for exactly `SETTLE_CYC` clocks, starting with the clock in which the new code appears.
- R11: A code change while the flag is already high restarts the full `SETTLE_CYC` window from that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_par | input | 1 | 1 = parallel programming, 0 = serial programming |
| en_i | input | 1 | Enable: pass-through/latch in parallel, load window in serial |
| sclk_i | input | 1 | Serial shift clock, sampled and edge-detected |
| sdata_i | input | 1 | Serial data in, MSB first |
| par_code_i | input | CODE_W | Parallel code bus |
| code_o | output | CODE_W | Active delay code |
| sdo_o | output | 1 | Serial data out (register MSB, or bus bit 0 in parallel mode) |
| settle_o | output | 1 | High while the delay element is settling after a code change |

## Verification
The hardest case to reach is a non-destructive read-back. Eight shifts must return the stored code and leave the register exactly as it was, and the enable fall after them must raise no settle flag. The stimulus reaches it by feeding the serial output sampled in each cycle back in as the next data bit, then checking the assembled read value, the code and the flag. Shift register isolation in parallel mode is checked at the ports in a second step. Serial clocks are applied in parallel mode, serial mode is entered, and the register contents are read out and activated.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef enum logic {
        PGM_SERIAL   = 1'b0,
        PGM_PARALLEL = 1'b1
    } pgm_mode_e;

endpackage

// File: rtl/dcp_strobe.sv
module dcp_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sclk_i,
    output logic en_fall,
    output logic sclk_rise
);

    typedef struct packed {
        logic en;
        logic sclk;
    } strb_t;

    strb_t s_d, s_q;

    always_comb begin
        s_d.en   = en_i;
        s_d.sclk = sclk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_fall   = s_q.en & ~en_i;
    assign sclk_rise = sclk_i & ~s_q.sclk;

endmodule

// File: rtl/dcp_shifter.sv
module dcp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr
);

    typedef struct packed {
        logic [W-1:0] bits;
    } shf_t;

    shf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_en) r_d.bits = {r_q.bits[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sr = r_q.bits;

endmodule

// File: rtl/dcp_settle.sv
module dcp_settle #(
    parameter int SETTLE_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } set_t;

    set_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load)               t_d.cnt = CNT_W'(SETTLE_CYC);
        else if (t_q.cnt != '0) t_d.cnt = t_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = (t_q.cnt != '0);

endmodule

// File: rtl/dly_code_prog.sv
module dly_code_prog #(
    parameter int CODE_W     = 8,
    parameter int SETTLE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_par,
    input  logic              en_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic [CODE_W-1:0] par_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sdo_o,
    output logic              settle_o
);
    import dcp_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } act_t;

    pgm_mode_e         mode;
    logic              en_fall;
    logic              sclk_rise;
    logic              shift_go;
    logic [CODE_W-1:0] shreg;
    logic              code_chg;
    act_t              a_d, a_q;

    assign mode = pgm_mode_e'(mode_par);

    dcp_strobe u_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .sclk_i    (sclk_i),
        .en_fall   (en_fall),
        .sclk_rise (sclk_rise)
    );

    assign shift_go = (mode == PGM_SERIAL) && en_i && sclk_rise;

    dcp_shifter #(.W(CODE_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_go),
        .din      (sdata_i),
        .sr       (shreg)
    );

    always_comb begin
        a_d = a_q;
        if (mode == PGM_PARALLEL) begin
            if (en_i) a_d.code = par_code_i;
        end else if (en_fall) begin
            a_d.code = shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign code_chg = (a_d.code != a_q.code);

    dcp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_set (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (code_chg),
        .busy  (settle_o)
    );

    assign code_o = a_q.code;
    assign sdo_o  = (mode == PGM_PARALLEL) ? par_code_i[0] : shreg[CODE_W-1];

endmodule

// File: rtl/dly_code_prog_chk.sv
module dly_code_prog_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_par,
    input logic              en_i,
    input logic [CODE_W-1:0] par_code_i,
    input logic [CODE_W-1:0] code_o,
    input logic              sdo_o,
    input logic              settle_o,
    input logic [CODE_W-1:0] shreg,
    input logic              en_fall,
    input logic              sclk_rise
);

    a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_par && en_i) |=> (code_o == $past(par_code_i)));

    a_r3_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_par && !en_i) |=> $stable(code_o));

    a_r4_par_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        mode_par |=> $stable(shreg));

    a_r5_ser_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && en_i) |=> $stable(code_o));

    a_r6_ser_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && !en_i) |=> $stable(shreg));

    a_r7_ser_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && en_fall) |=> (code_o == $past(shreg)));

    a_r8_ser_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && en_i && sclk_rise) |=> (sdo_o == $past(shreg[CODE_W-2]) || mode_par));

    a_r10_settle_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> settle_o);

endmodule

bind dly_code_prog dly_code_prog_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_par   (mode_par),
    .en_i       (en_i),
    .par_code_i (par_code_i),
    .code_o     (code_o),
    .sdo_o      (sdo_o),
    .settle_o   (settle_o),
    .shreg      (shreg),
    .en_fall    (en_fall),
    .sclk_rise  (sclk_rise)
);

// File: tb/sim_dly_code_prog.sv
`timescale 1ns/1ps
module sim_dly_code_prog;

    localparam int W  = 8;
    localparam int SC = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_par = 1'b0;
    logic         en_i = 1'b0;
    logic         sclk_i = 1'b0;
    logic         sdata_i = 1'b0;
    logic [W-1:0] par_code_i = '0;
    logic [W-1:0] code_o;
    logic         sdo_o;
    logic         settle_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dly_code_prog #(.CODE_W(W), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .en_i(en_i),
        .sclk_i(sclk_i), .sdata_i(sdata_i), .par_code_i(par_code_i),
        .code_o(code_o), .sdo_o(sdo_o), .settle_o(settle_o)
    );

    // {en, parallel bus, expected code}
    localparam logic [16:0] PVEC [6] = '{
        {1'b1, 8'hA5, 8'hA5},
        {1'b1, 8'h3C, 8'h3C},
        {1'b0, 8'hFF, 8'h3C},
        {1'b0, 8'h00, 8'h3C},
        {1'b1, 8'h81, 8'h81},
        {1'b0, 8'h7E, 8'h81}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        sdata_i = b; sclk_i = 1'b1; tick();
        sclk_i = 1'b0; tick();
    endtask

    task automatic settle_wait();
        for (int i = 0; i < SC + 2; i++) tick();
    endtask

    task automatic count_settle(string req);
        int hi = 0;
        for (int i = 0; i < SC + 4; i++) begin
            if (settle_o) hi++;
            tick();
        end
        check(req, hi, SC);
    endtask

    // serial write; check sdo streams old contents (R8), code holds (R5), load (R7)
    task automatic serial_write(logic [W-1:0] val, logic [W-1:0] old_sr, logic [W-1:0] old_code);
        mode_par = 1'b0; en_i = 1'b1; tick();
        check("R8 msb on enable rise", sdo_o, old_sr[W-1]);
        for (int i = W - 1; i >= 0; i--) begin
            check("R8 old contents out", sdo_o, old_sr[i]);
            shift_bit(val[i]);
        end
        check("R5 code holds while loading", code_o, old_code);
        en_i = 1'b0; tick();
        check("R7 load on enable fall", code_o, val);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        @(negedge clk); @(negedge clk);
        check("R1 reset code", code_o, 8'h00);
        check("R1 reset settle", settle_o, 1'b0);
        check("R1 reset sdo", sdo_o, 1'b0);
        rst_n = 1'b1; tick();
        check("R1 code after release", code_o, 8'h00);

        // parallel vector table: R2 / R3 / R4
        mode_par = 1'b1;
        for (int k = 0; k < 6; k++) begin
            en_i = PVEC[k][16]; par_code_i = PVEC[k][15:8];
            #0;
            check("R4 sdo mirrors bus bit0", sdo_o, PVEC[k][8]);
            tick();
            check(PVEC[k][16] ? "R2 pass-through" : "R3 hold", code_o, PVEC[k][7:0]);
        end
        settle_wait();
        check("R10 settle cleared", settle_o, 1'b0);

        // R4: serial clocks in parallel mode must not touch the register
        en_i = 1'b1; par_code_i = 8'h81;
        for (int i = 0; i < W; i++) shift_bit(1'b1);
        check("R4 code unaffected", code_o, 8'h81);
        en_i = 1'b0; tick();
        mode_par = 1'b0; en_i = 1'b1; tick();
        check("R4 register still zero msb", sdo_o, 1'b0);
        en_i = 1'b0; tick();
        check("R4 register zero activated", code_o, 8'h00);
        settle_wait();

        // R6: clocks with enable low ignored
        for (int i = 0; i < W; i++) shift_bit(1'b1);
        en_i = 1'b1; tick(); en_i = 1'b0; tick();
        check("R6 register untouched", code_o, 8'h00);
        check("R6 no settle", settle_o, 1'b0);

        // R5 / R7 / R8 / R10
        serial_write(8'hC6, 8'h00, 8'h00);
        settle_wait();
        serial_write(8'h5A, 8'hC6, 8'hC6);
        count_settle("R10 settle window length");

        // R9 read-back with loopback
        rd = '0;
        en_i = 1'b1; tick();
        for (int i = 0; i < W; i++) begin
            rd = {rd[W-2:0], sdo_o};
            shift_bit(sdo_o);
        end
        check("R9 read value", rd, 8'h5A);
        en_i = 1'b0; tick();
        check("R9 code unchanged", code_o, 8'h5A);
        check("R9 no settle", settle_o, 1'b0);
        en_i = 1'b1; tick();
        check("R9 register restored msb", sdo_o, 1'b0);
        en_i = 1'b0; tick();

        // R11 restart
        mode_par = 1'b1; en_i = 1'b1; par_code_i = 8'h22; tick();
        tick(); tick();
        par_code_i = 8'h33; tick();
        check("R11 code second change", code_o, 8'h33);
        count_settle("R11 window restarted");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule